// File: doc/BRIEF.md
# Single-Channel Fly-By DMA Engine

This block moves a run of bytes between one I/O device and memory without the processor touching the data. Software loads a start address, a byte count and a direction while the engine is idle. The engine then waits for the device to request service and asks the processor for the bus with a hold line. Once the grant comes back, it acknowledges the device and runs fly-by cycles. In each cycle the engine drives the memory address and pulses one I/O strobe and the opposite memory strobe together, so the byte goes straight from source to destination.

Each transfer advances the address by one and lowers the remaining count by one. When the count runs out, the engine drops hold and acknowledge, returns to idle and raises a sticky done flag. If the device withdraws its request partway through, the engine gives the bus back after the cycle in progress. It picks up from the same address and count on the next request.

Top module: `dma_flyby`

## Requirements
- R1: After reset, bus_hold, dev_ack, busy, done and all four strobes are low.
- R2: A configuration write (cfg_we) is accepted only while busy is low. While busy is high it has no effect: the address sequence and transfer count of the running job are unchanged. An accepted write with a nonzero count raises busy and clears done on the next cycle.
- R3: While busy is high and bus_hold is low, a high dev_req sampled at a clock edge raises bus_hold after that edge.
- R4: dev_ack rises only on the edge after bus_hlda is sampled high with bus_hold asserted. The fly-by strobes follow on the next edge.
- R5: With cfg_dir = 0 (device to memory), a transfer pulses io_rd and mem_wr together. With cfg_dir = 1 (memory to device), it pulses mem_rd and io_wr together. Each strobe pulse lasts exactly one cycle.
- R6: The first transfer presents the programmed address on mem_addr. Each later transfer presents the previous address plus one, wrapping modulo 2^AW.
- R7: Exactly cfg_count transfers take place. After the last one, bus_hold, dev_ack and busy are low and done is high on the next cycle. done stays high until the next accepted configuration write.
- R8: If dev_req is low at the edge that ends a transfer with bytes still left, bus_hold and dev_ack drop after that edge and the job resumes on a later request. If dev_req is high there, hold and acknowledge stay up and the next strobe follows one idle cycle later.
- R9: A strobe is high only while bus_hlda and dev_ack are both high.
- R10: An accepted configuration write with cfg_count = 0 sets done on the next cycle, leaves busy low and never raises bus_hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe, honoured only while idle |
| cfg_addr | input | AW | Start memory address |
| cfg_count | input | CW | Number of bytes to move |
| cfg_dir | input | 1 | 0: device to memory, 1: memory to device |
| dev_req | input | 1 | Service request from the device |
| dev_ack | output | 1 | Acknowledge to the device |
| bus_hold | output | 1 | Bus request to the processor |
| bus_hlda | input | 1 | Bus grant from the processor |
| mem_addr | output | AW | Memory address of the current transfer |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| busy | output | 1 | A job is loaded and not yet finished |
| done | output | 1 | Last job finished; sticky until the next load |

## Verification
All outputs decode directly from registered state, so every response falls exactly one edge after the input that causes it:
- hold follows a sampled request one cycle later.
- acknowledge follows a sampled grant one cycle later.
- the strobe follows acknowledge one cycle later.
- release and done follow the edge that ends the final or interrupted transfer one cycle later.

The bench changes its inputs just after the rising edge and reads outputs at the falling edge. At each falling edge it records which response the sampled condition calls for, and checks it at the next falling edge, one cycle later. The processor model grants the bus after a random delay of zero to two cycles, and device requests are dropped at random. Both the release path and the resume path are therefore taken many times, alongside directed cases for a zero count, a single byte, address wrap and a configuration write issued mid-job.

// File: rtl/dma_flyby_pkg.sv
package dma_flyby_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_REQ,
        ST_ACK,
        ST_XFER
    } dma_state_e;
endpackage

// File: rtl/dma_flyby_regs.sv
module dma_flyby_regs #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] ld_addr,
    input  logic [CW-1:0] ld_count,
    input  logic          ld_dir,
    output logic [AW-1:0] addr,
    output logic          dir,
    output logic          last
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic          dir;
    } regs_t;

    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.addr = ld_addr;
            r_d.cnt  = ld_count;
            r_d.dir  = ld_dir;
        end else if (step) begin
            r_d.addr = r_q.addr + AW'(1);
            r_d.cnt  = r_q.cnt - CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign addr = r_q.addr;
    assign dir  = r_q.dir;
    assign last = (r_q.cnt == CNT_ONE);
endmodule

// File: rtl/dma_flyby_ctrl.sv
module dma_flyby_ctrl
    import dma_flyby_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_zero,
    input  logic       dev_req,
    input  logic       hlda,
    input  logic       last,
    output logic       load,
    output logic       step,
    output dma_state_e state,
    output logic       done
);
    typedef struct packed {
        dma_state_e st;
        logic       done;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d  = c_q;
        load = 1'b0;
        step = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (cfg_we) begin
                    load = 1'b1;
                    if (cfg_zero) begin
                        c_d.done = 1'b1;
                    end else begin
                        c_d.done = 1'b0;
                        c_d.st   = ST_ARM;
                    end
                end
            end
            ST_ARM:  if (dev_req) c_d.st = ST_REQ;
            ST_REQ:  if (hlda)    c_d.st = ST_ACK;
            ST_ACK:  c_d.st = hlda ? ST_XFER : ST_REQ;
            ST_XFER: begin
                step = 1'b1;
                if (last) begin
                    c_d.st   = ST_IDLE;
                    c_d.done = 1'b1;
                end else if (dev_req) begin
                    c_d.st = ST_ACK;
                end else begin
                    c_d.st = ST_ARM;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, done: 1'b0};
        else        c_q <= c_d;
    end

    assign state = c_q.st;
    assign done  = c_q.done;
endmodule

// File: rtl/dma_flyby.sv
module dma_flyby
    import dma_flyby_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic          cfg_dir,
    input  logic          dev_req,
    output logic          dev_ack,
    output logic          bus_hold,
    input  logic          bus_hlda,
    output logic [AW-1:0] mem_addr,
    output logic          io_rd,
    output logic          io_wr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          busy,
    output logic          done
);
    dma_state_e state;
    logic       load, step, last, dir, xfer;

    dma_flyby_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_zero (cfg_count == '0),
        .dev_req  (dev_req),
        .hlda     (bus_hlda),
        .last     (last),
        .load     (load),
        .step     (step),
        .state    (state),
        .done     (done)
    );

    dma_flyby_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .ld_addr  (cfg_addr),
        .ld_count (cfg_count),
        .ld_dir   (cfg_dir),
        .addr     (mem_addr),
        .dir      (dir),
        .last     (last)
    );

    assign xfer     = (state == ST_XFER);
    assign bus_hold = (state == ST_REQ) || (state == ST_ACK) || xfer;
    assign dev_ack  = (state == ST_ACK) || xfer;
    assign busy     = (state != ST_IDLE);
    assign io_rd    = xfer && !dir;
    assign mem_wr   = xfer && !dir;
    assign mem_rd   = xfer && dir;
    assign io_wr    = xfer && dir;
endmodule

// File: rtl/dma_flyby_chk.sv
module dma_flyby_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic          dev_req,
    input logic          dev_ack,
    input logic          bus_hold,
    input logic          bus_hlda,
    input logic [AW-1:0] mem_addr,
    input logic          io_rd,
    input logic          io_wr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          busy,
    input logic          done
);
    logic strobe;
    assign strobe = io_rd || io_wr || mem_rd || mem_wr;

    p_strobe_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (bus_hlda && dev_ack));

    p_strobe_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd == mem_wr) && (io_wr == mem_rd) && !(io_rd && io_wr));

    p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (mem_addr == AW'($past(mem_addr) + 1'b1)));

    p_hold_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bus_hold && dev_req) |=> bus_hold);

    p_ack_after_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_ack) |-> $past(bus_hlda && bus_hold));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !bus_hold && !dev_ack));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !dev_req) |=> (!dev_ack && !bus_hold));

    p_busy_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_we && !strobe) |=> $stable(mem_addr));
endmodule

bind dma_flyby dma_flyby_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .dev_req  (dev_req),
    .dev_ack  (dev_ack),
    .bus_hold (bus_hold),
    .bus_hlda (bus_hlda),
    .mem_addr (mem_addr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .busy     (busy),
    .done     (done)
);

// File: tb/sim_dma_flyby.sv
`timescale 1ns/1ps
module sim_dma_flyby;
    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          cfg_dir = 1'b0;
    logic          dev_req = 1'b0;
    logic          bus_hlda = 1'b0;
    logic          dev_ack, bus_hold, io_rd, io_wr, mem_rd, mem_wr, busy, done;
    logic [AW-1:0] mem_addr;

    always #2.5 clk = ~clk;

    dma_flyby #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_count(cfg_count), .cfg_dir(cfg_dir), .dev_req(dev_req),
        .dev_ack(dev_ack), .bus_hold(bus_hold), .bus_hlda(bus_hlda),
        .mem_addr(mem_addr), .io_rd(io_rd), .io_wr(io_wr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [AW-1:0] e_addr;
    int            e_left = 0;
    logic          e_dir = 1'b0;
    int            e_xfers = 0;
    bit p_hold, p_ack, p_strb, p_end, p_drop, p_cont;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // strobe order {io_rd, io_wr, mem_rd, mem_wr}
    function automatic logic [3:0] exp_pair(input logic d);
        return d ? 4'b0110 : 4'b1001;
    endfunction

    // processor model: grants hold after 0..2 cycles, releases at once
    initial begin
        int gdly = 0;
        forever begin
            @(posedge clk); #1;
            if (!bus_hold) begin
                bus_hlda = 1'b0;
                gdly = int'($urandom % 3);
            end else if (!bus_hlda) begin
                if (gdly == 0) bus_hlda = 1'b1;
                else gdly--;
            end
        end
    end

    // monitor: settles last cycle's predictions, then makes new ones
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                logic strobe;
                strobe = io_rd | io_wr | mem_rd | mem_wr;
                if (p_hold) chk(bus_hold, "R3", "hold after request", bus_hold, 1);
                if (p_ack)  chk(dev_ack, "R4", "ack after grant", dev_ack, 1);
                if (p_strb) chk(strobe, "R4", "strobe after ack", strobe, 1);
                if (p_end)  chk(done && !busy && !bus_hold && !dev_ack, "R7",
                                "finish {done,busy,hold,ack}",
                                {done, busy, bus_hold, dev_ack}, 4'b1000);
                if (p_drop) chk(!bus_hold && !dev_ack, "R8", "release {hold,ack}",
                                {bus_hold, dev_ack}, 2'b00);
                if (p_cont) chk(bus_hold && dev_ack && !strobe, "R8",
                                "continue {hold,ack,strobe}",
                                {bus_hold, dev_ack, strobe}, 3'b110);
                p_end = 0; p_drop = 0; p_cont = 0;
                if (strobe) begin
                    chk(bus_hlda && dev_ack, "R9", "grant and ack with strobe",
                        {bus_hlda, dev_ack}, 2'b11);
                    chk({io_rd, io_wr, mem_rd, mem_wr} == exp_pair(e_dir), "R5",
                        "strobe pair", {io_rd, io_wr, mem_rd, mem_wr}, exp_pair(e_dir));
                    chk(mem_addr == e_addr, "R6", "address", mem_addr, e_addr);
                    chk(e_left > 0, "R7", "transfer beyond count", e_xfers + 1, e_xfers);
                    e_addr = e_addr + AW'(1);
                    e_left--;
                    e_xfers++;
                    p_end  = (e_left == 0);
                    p_drop = (e_left > 0) && !dev_req;
                    p_cont = (e_left > 0) && dev_req;
                end
                p_hold = busy && !bus_hold && dev_req;
                p_ack  = bus_hold && bus_hlda && !dev_ack;
                p_strb = dev_ack && !strobe && bus_hlda;
            end
        end
    end

    task automatic run_job(input logic [AW-1:0] a, input int cnt, input logic d,
                           input int req_pct, input bit poke);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_count = CW'(cnt); cfg_dir = d;
        e_addr = a; e_left = cnt; e_dir = d; e_xfers = 0;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        @(negedge clk);
        if (cnt == 0) begin
            chk(done && !busy && !bus_hold, "R10", "zero count {done,busy,hold}",
                {done, busy, bus_hold}, 3'b100);
            return;
        end
        chk(busy && !done, "R2", "load accepted {busy,done}", {busy, done}, 2'b10);
        for (int c = 0; c < 4000; c++) begin
            @(posedge clk); #1;
            dev_req = (int'($urandom % 100) < req_pct);
            if (poke && c == 6) begin
                cfg_we = 1'b1; cfg_addr = ~a; cfg_count = CW'(2); cfg_dir = ~d;
            end else begin
                cfg_we = 1'b0;
            end
            if (done && !busy) break;
        end
        dev_req = 1'b0; cfg_we = 1'b0;
        chk(e_xfers == cnt, poke ? "R2" : "R7", "transfer count", e_xfers, cnt);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done && !bus_hold, "R7", "done sticky, hold low", {done, bus_hold}, 2'b10);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({bus_hold, dev_ack, busy, done, io_rd, io_wr, mem_rd, mem_wr} == 8'h00,
            "R1", "reset outputs",
            {bus_hold, dev_ack, busy, done, io_rd, io_wr, mem_rd, mem_wr}, 0);
        #1 rst_n = 1'b1;

        run_job(16'h0000, 0, 1'b0, 100, 0);      // R10
        run_job(16'h1234, 1, 1'b0, 100, 0);      // single byte
        run_job(16'hFFFD, 5, 1'b1, 100, 0);      // R6 wrap
        run_job(16'h4000, 16, 1'b0, 100, 1);     // R2 write while busy
        run_job(16'h0800, 12, 1'b1, 30, 0);      // R8 frequent drops
        for (int j = 0; j < 20; j++) begin
            run_job(AW'($urandom), 1 + int'($urandom % 14), 1'($urandom),
                    20 + int'($urandom % 80), 0);
        end
        run_job(16'h0000, 0, 1'b1, 100, 0);      // R10 after activity

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule